// File: doc/BRIEF.md
# USB Device Control Register Bank

This block is the CPU-facing register bank of a low-speed USB device interface. An 8-bit processor bus reaches four byte-wide registers at consecutive offsets: interrupt status, interrupt mask, control and device address. Event strobes from the USB serial core set status bits. The control register drives resume signalling, regulator power-down, suspend and a forced interface reset back to that core. A single interrupt request line goes to the CPU.

Software clears status bits by writing a full byte in which bits to keep are 1 and bits to clear are 0. This means that a plain store never loses an event that arrived after the last read. Suspend is set by software and is dropped by hardware when the core reports bus activity. A forced reset holds the interface and its address in reset until software releases it. The release is announced through the reset status bit.

Top module: `usb_ctl_regs`

## Requirements
- R1: After reset, offset 0 (status) reads 00h, offset 1 (mask) reads 00h, offset 2 (control) reads 06h and offset 3 (address) reads 00h. Reads return data combinationally from `addr_i`.
- R2: A strobe on `evt_i[k]` sets status bit k on the next clock edge. Bit 0 is the start-of-frame keep-alive and bit 1 is the reset bit.
- R3: A write to offset 0 clears each status bit written 0 and leaves each bit written 1 unchanged. Status bit 7 always reads 0.
- R4: If an event strobe and a write-0 hit the same status bit in the same cycle, the bit ends up set.
- R5: The mask register at offset 1 stores bits 6:0 as written. Its bit 7 always reads 0.
- R6: `irq_o` is 1 exactly when some status bit and its mask bit are both 1 and `irq_dis_i` is 0.
- R7: The control register at offset 2 stores bits 3:0, and bits 7:4 read 0. The bits map as follows: bit 3 drives `resume_o`, bit 2 drives `pdwn_o`, bit 1 drives `susp_o` and bit 0 drives `core_rst_o`.
- R8: A pulse on `activity_i` clears control bit 1 (suspend) on the next edge. This also holds when a write in the same cycle sets that bit.
- R9: A write that changes control bit 0 from 1 to 0 sets status bit 1.
- R10: A pulse on `bus_reset_i` sets status bit 1 and clears the device address on the next edge. The address register at offset 3 holds 7 bits, and its bit 7 reads 0.
- R11: While control bit 0 is 1, the device address is held at 0 and writes to offset 3 have no effect.
- R12: Control bit 3 (resume) changes only through CPU writes. Activity and bus reset leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Bus access select |
| wr_i | input | 1 | Write enable, qualified by sel_i |
| addr_i | input | 2 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| evt_i | input | 7 | Status-setting event strobes from the USB core |
| bus_reset_i | input | 1 | Host bus reset detected |
| activity_i | input | 1 | Bus activity detected |
| irq_dis_i | input | 1 | CPU global interrupt disable |
| irq_o | output | 1 | Interrupt request |
| resume_o | output | 1 | Resume signalling request |
| pdwn_o | output | 1 | Regulator power-down |
| susp_o | output | 1 | Suspend mode |
| core_rst_o | output | 1 | Forced interface reset |
| dev_addr_o | output | 7 | Device address |

## Verification
Two pairs of functions can coincide in one cycle. The first is a hardware event strobe and a CPU write-0 clear on the same status bit. The second is an activity pulse and a CPU write that sets suspend. Both pairs are provoked deliberately by directed cycles, and they also arise often under random stimulus, where strobes and writes are drawn independently every cycle. The expected outcome follows R4 and R8: the hardware side wins. A bench model built from the requirements judges every cycle by comparing all outputs and the read data.

// File: rtl/usb_ctl_pkg.sv
package usb_ctl_pkg;
  typedef enum logic [1:0] {
    OFF_STAT = 2'd0,
    OFF_MASK = 2'd1,
    OFF_CTRL = 2'd2,
    OFF_ADDR = 2'd3
  } reg_off_e;

  localparam int unsigned B_FRES   = 0;
  localparam int unsigned B_SUSP   = 1;
  localparam int unsigned B_PDWN   = 2;
  localparam int unsigned B_RESUME = 3;
  localparam int unsigned ST_RESET = 1;
endpackage

// File: rtl/usb_ctl_status.sv
module usb_ctl_status #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  q_o[i] <= 1'b0;
      else if (set_i[i])            q_o[i] <= 1'b1;  // set beats clear
      else if (we_i && !wdata_i[i]) q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/usb_ctl_ctrl.sv
module usb_ctl_ctrl import usb_ctl_pkg::*; #(
  parameter int unsigned       CW       = 4,
  parameter int unsigned       DAW      = 7,
  parameter logic [CW-1:0]     CTRL_RST = 4'h6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ctrl_we_i,
  input  logic           addr_we_i,
  input  logic [CW-1:0]  ctrl_wdata_i,
  input  logic [DAW-1:0] addr_wdata_i,
  input  logic           activity_i,
  input  logic           bus_reset_i,
  output logic [CW-1:0]  ctrl_q_o,
  output logic [DAW-1:0] dev_addr_o,
  output logic           fres_rel_o
);
  assign fres_rel_o = ctrl_q_o[B_FRES] & ctrl_we_i & ~ctrl_wdata_i[B_FRES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q_o <= CTRL_RST;
    end else begin
      if (ctrl_we_i)  ctrl_q_o <= ctrl_wdata_i;
      if (activity_i) ctrl_q_o[B_SUSP] <= 1'b0;  // hardware wins
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              dev_addr_o <= '0;
    else if (bus_reset_i || ctrl_q_o[B_FRES]) dev_addr_o <= '0;
    else if (addr_we_i)                       dev_addr_o <= addr_wdata_i;
  end
endmodule

// File: rtl/usb_ctl_regs.sv
module usb_ctl_regs import usb_ctl_pkg::*; #(
  parameter int unsigned   DW       = 8,
  parameter int unsigned   NEV      = 7,
  parameter int unsigned   CW       = 4,
  parameter int unsigned   DAW      = 7,
  parameter logic [CW-1:0] CTRL_RST = 4'h6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sel_i,
  input  logic           wr_i,
  input  logic [1:0]     addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  input  logic [NEV-1:0] evt_i,
  input  logic           bus_reset_i,
  input  logic           activity_i,
  input  logic           irq_dis_i,
  output logic           irq_o,
  output logic           resume_o,
  output logic           pdwn_o,
  output logic           susp_o,
  output logic           core_rst_o,
  output logic [DAW-1:0] dev_addr_o
);
  logic           wr_en;
  logic           we_stat, we_mask, we_ctrl, we_addr;
  logic [NEV-1:0] stat_q, mask_q, stat_set;
  logic [CW-1:0]  ctrl_q;
  logic           fres_rel;
  logic           unused_wd;

  assign unused_wd = ^wdata_i;
  assign wr_en   = sel_i & wr_i;
  assign we_stat = wr_en && (reg_off_e'(addr_i) == OFF_STAT);
  assign we_mask = wr_en && (reg_off_e'(addr_i) == OFF_MASK);
  assign we_ctrl = wr_en && (reg_off_e'(addr_i) == OFF_CTRL);
  assign we_addr = wr_en && (reg_off_e'(addr_i) == OFF_ADDR);

  always_comb begin
    stat_set = evt_i;
    stat_set[ST_RESET] = evt_i[ST_RESET] | bus_reset_i | fres_rel;
  end

  usb_ctl_status #(.N(NEV)) u_stat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_stat),
    .wdata_i (wdata_i[NEV-1:0]),
    .set_i   (stat_set),
    .q_o     (stat_q)
  );

  usb_ctl_ctrl #(.CW(CW), .DAW(DAW), .CTRL_RST(CTRL_RST)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_we_i    (we_ctrl),
    .addr_we_i    (we_addr),
    .ctrl_wdata_i (wdata_i[CW-1:0]),
    .addr_wdata_i (wdata_i[DAW-1:0]),
    .activity_i   (activity_i),
    .bus_reset_i  (bus_reset_i),
    .ctrl_q_o     (ctrl_q),
    .dev_addr_o   (dev_addr_o),
    .fres_rel_o   (fres_rel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (we_mask) mask_q <= wdata_i[NEV-1:0];
  end

  always_comb begin
    rdata_o = '0;
    unique case (reg_off_e'(addr_i))
      OFF_STAT: rdata_o[NEV-1:0] = stat_q;
      OFF_MASK: rdata_o[NEV-1:0] = mask_q;
      OFF_CTRL: rdata_o[CW-1:0]  = ctrl_q;
      OFF_ADDR: rdata_o[DAW-1:0] = dev_addr_o;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o      = (|(stat_q & mask_q)) & ~irq_dis_i;
  assign resume_o   = ctrl_q[B_RESUME];
  assign pdwn_o     = ctrl_q[B_PDWN];
  assign susp_o     = ctrl_q[B_SUSP];
  assign core_rst_o = ctrl_q[B_FRES];
endmodule

// File: rtl/usb_ctl_regs_chk.sv
module usb_ctl_regs_chk #(
  parameter int unsigned DW  = 8,
  parameter int unsigned NEV = 7,
  parameter int unsigned DAW = 7
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           sel_i,
  input logic           wr_i,
  input logic [1:0]     addr_i,
  input logic [NEV-1:0] evt_i,
  input logic           bus_reset_i,
  input logic           activity_i,
  input logic           irq_dis_i,
  input logic [DW-1:0]  rdata_o,
  input logic           irq_o,
  input logic           resume_o,
  input logic           susp_o,
  input logic           core_rst_o,
  input logic [DAW-1:0] dev_addr_o,
  input logic [NEV-1:0] stat_q
);
  p_evt_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

  p_irq_dis_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_dis_i |-> !irq_o);

  p_ctrl_rsvd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd2) |-> (rdata_o[DW-1:4] == '0));

  p_susp_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    activity_i |=> !susp_o);

  p_fres_rel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_rst_o) |-> stat_q[1]);

  p_bus_rst_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> (dev_addr_o == '0) && stat_q[1]);

  p_addr_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o |=> (dev_addr_o == '0));

  p_resume_sw_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && wr_i && addr_i == 2'd2) |=> $stable(resume_o));
endmodule

bind usb_ctl_regs usb_ctl_regs_chk #(.DW(DW), .NEV(NEV), .DAW(DAW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sel_i       (sel_i),
  .wr_i        (wr_i),
  .addr_i      (addr_i),
  .evt_i       (evt_i),
  .bus_reset_i (bus_reset_i),
  .activity_i  (activity_i),
  .irq_dis_i   (irq_dis_i),
  .rdata_o     (rdata_o),
  .irq_o       (irq_o),
  .resume_o    (resume_o),
  .susp_o      (susp_o),
  .core_rst_o  (core_rst_o),
  .dev_addr_o  (dev_addr_o),
  .stat_q      (stat_q)
);

// File: tb/usb_ctl_regs_tb_top.sv
`timescale 1ns/1ps
module usb_ctl_regs_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel_i = 1'b0, wr_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic [6:0] evt_i = 7'h00;
  logic       bus_reset_i = 1'b0, activity_i = 1'b0, irq_dis_i = 1'b0;
  logic       irq_o, resume_o, pdwn_o, susp_o, core_rst_o;
  logic [6:0] dev_addr_o;

  int errors = 0;
  int checks = 0;
  logic [6:0] m_st, m_mk, m_ad;
  logic [3:0] m_ct;

  always #10 clk_i = ~clk_i;

  usb_ctl_regs dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .evt_i(evt_i),
    .bus_reset_i(bus_reset_i), .activity_i(activity_i), .irq_dis_i(irq_dis_i),
    .irq_o(irq_o), .resume_o(resume_o), .pdwn_o(pdwn_o), .susp_o(susp_o),
    .core_rst_o(core_rst_o), .dev_addr_o(dev_addr_o)
  );

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return {1'b0, m_st};
      2'd1:    return {1'b0, m_mk};
      2'd2:    return {4'h0, m_ct};
      default: return {1'b0, m_ad};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic clr_in();
    sel_i = 0; wr_i = 0; wdata_i = 0; evt_i = 0;
    bus_reset_i = 0; activity_i = 0;
  endtask

  // one clock: advance model from requirements, then compare every output
  task automatic cyc(input string tag);
    logic       w, rel;
    logic [6:0] st_n, mk_n, ad_n, set;
    logic [3:0] ct_n;
    w    = sel_i & wr_i;
    rel  = m_ct[0] && w && addr_i == 2'd2 && !wdata_i[0];
    set  = evt_i | {5'b0, bus_reset_i | rel, 1'b0};
    st_n = ((w && addr_i == 2'd0) ? (m_st & wdata_i[6:0]) : m_st) | set;
    mk_n = (w && addr_i == 2'd1) ? wdata_i[6:0] : m_mk;
    ct_n = (w && addr_i == 2'd2) ? wdata_i[3:0] : m_ct;
    if (activity_i) ct_n[1] = 1'b0;
    ad_n = (bus_reset_i || m_ct[0]) ? 7'h00 : (w && addr_i == 2'd3) ? wdata_i[6:0] : m_ad;
    @(posedge clk_i);
    #1;
    m_st = st_n; m_mk = mk_n; m_ct = ct_n; m_ad = ad_n;
    #4;
    chk(tag, {12'h0, rdata_o, irq_o, resume_o, pdwn_o, susp_o, core_rst_o, dev_addr_o},
        {12'h0, exp_rd(addr_i), (|(m_st & m_mk)) & ~irq_dis_i, m_ct, m_ad});
    @(negedge clk_i);
    clr_in();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
    sel_i = 1; wr_i = 1; addr_i = a; wdata_i = d;
    cyc(tag);
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    addr_i = a;
    cyc(tag);
    #1 chk(tag, {24'h0, rdata_o}, {24'h0, exp});
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0718));
    m_st = 0; m_mk = 0; m_ct = 4'h6; m_ad = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    rd(2'd0, 8'h00, "R1 status");
    rd(2'd1, 8'h00, "R1 mask");
    rd(2'd2, 8'h06, "R1 ctrl");
    rd(2'd3, 8'h00, "R1 addr");
    // R2 start-of-frame strobe sets bit 0
    evt_i = 7'h01; addr_i = 2'd0; cyc("R2 sof");
    rd(2'd0, 8'h01, "R2 sof read");
    // R3 write-1 keeps, write-0 clears
    evt_i = 7'h7F; cyc("R3 set all");
    wr(2'd0, 8'hFF, "R3 keep");
    rd(2'd0, 8'h7F, "R3 keep read");
    wr(2'd0, 8'h7E, "R3 clr bit0");
    rd(2'd0, 8'h7E, "R3 clr read");
    // R4 set beats clear
    addr_i = 2'd0; sel_i = 1; wr_i = 1; wdata_i = 8'h00; evt_i = 7'h04;
    cyc("R4 collide");
    rd(2'd0, 8'h04, "R4 collide read");
    // R5 mask reserved bit
    wr(2'd1, 8'hFF, "R5 mask wr");
    rd(2'd1, 8'h7F, "R5 mask read");
    // R6 interrupt gating
    #1 chk("R6 irq on", {31'h0, irq_o}, 32'h1);
    irq_dis_i = 1; #1 chk("R6 irq disabled", {31'h0, irq_o}, 32'h0);
    irq_dis_i = 0;
    wr(2'd1, 8'h01, "R6 mask other");
    #1 chk("R6 irq masked", {31'h0, irq_o}, 32'h0);
    // R7 control outputs and reserved bits
    wr(2'd2, 8'hFE, "R7 ctrl wr");
    rd(2'd2, 8'h0E, "R7 ctrl read");
    #1 chk("R7 outs", {28'h0, resume_o, pdwn_o, susp_o, core_rst_o}, 32'hE);
    // R8 activity clears suspend, also over a same-cycle set
    activity_i = 1; addr_i = 2'd2; cyc("R8 act");
    #1 chk("R8 susp clr", {31'h0, susp_o}, 32'h0);
    sel_i = 1; wr_i = 1; addr_i = 2'd2; wdata_i = 8'h0A; activity_i = 1;
    cyc("R8 collide");
    #1 chk("R8 collide susp", {31'h0, susp_o}, 32'h0);
    // R12 resume untouched by hardware
    bus_reset_i = 1; activity_i = 1; cyc("R12 hw");
    #1 chk("R12 resume kept", {31'h0, resume_o}, 32'h1);
    // R10 bus reset clears address, sets reset status
    wr(2'd0, 8'h00, "R10 clr stat");
    wr(2'd3, 8'hD5, "R10 addr wr");
    rd(2'd3, 8'h55, "R10 addr read");
    bus_reset_i = 1; addr_i = 2'd3; cyc("R10 busrst");
    rd(2'd3, 8'h00, "R10 addr cleared");
    rd(2'd0, 8'h02, "R10 reset status");
    // R11 forced reset holds address; R9 release sets reset status
    wr(2'd3, 8'h22, "R11 pre");
    wr(2'd0, 8'h00, "R9 clr stat");
    wr(2'd2, 8'h01, "R11 force");
    rd(2'd3, 8'h00, "R11 held");
    wr(2'd3, 8'h33, "R11 ignored wr");
    rd(2'd3, 8'h00, "R11 still held");
    rd(2'd0, 8'h00, "R9 before release");
    wr(2'd2, 8'h00, "R9 release");
    rd(2'd0, 8'h02, "R9 reset status");
    // random mix; collisions of R4 and R8 arise naturally
    for (int i = 0; i < 4000; i++) begin
      sel_i = ($urandom % 3) != 0;
      wr_i = $urandom % 2;
      addr_i = 2'($urandom);
      wdata_i = 8'($urandom);
      evt_i = (($urandom % 4) == 0) ? 7'($urandom) : 7'h00;
      bus_reset_i = ($urandom % 32) == 0;
      activity_i = ($urandom % 8) == 0;
      irq_dis_i = ($urandom % 4) == 0;
      cyc("R2 R3 R4 R6 R8 R9 R11 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule